// File: doc/BRIEF.md
# Six-Stage Pipeline Forwarding and Hazard Controller

This combinational unit steers operand bypassing and stage control for an in-order RV32I pipeline with six stages: fetch, decode, execute, two data-memory stages and write-back. Data memory is pipelined. A request leaves in the first memory stage, and its data is only valid in the register between the second memory stage and write-back. Two memory operations can be in flight at once, and memory keeps them in order.

Each cycle the unit looks at three things. The first is the source indices of the instruction in execute, which it uses to pick a bypass source for each ALU operand. The second is the source indices and use flags of the instruction in decode, which it uses to detect load-use dependencies that no bypass can cover. The third is the destination, write-enable and load flag held in each downstream pipeline register.

A taken branch or jump resolved in execute raises a redirect. The unit then flushes the two youngest stages. The control path works in one of three named modes:

- `PIPE_RUN`: all stages advance.
- `PIPE_STALL`: the PC and the fetch/decode register hold, and a bubble enters execute.
- `PIPE_FLUSH`: the PC loads the redirect target, and the fetch/decode and decode/execute registers are cleared.

The mode is chosen each cycle from the inputs alone:

- `RUN`→`STALL` when a load-use hazard appears.
- `STALL`→`RUN` when the load has moved far enough ahead.
- Any mode→`FLUSH` on a redirect, which wins over a stall.

Top module: `hz6_hazard_unit`

## Requirements
- R1: Each operand select is 2 bits wide with these codes: 0 = register file, 1 = execute/mem1 register, 2 = mem1/mem2 register, 3 = mem2/write-back register. A register is a candidate only when its write-enable is 1 and its destination equals the operand index.
- R2: When several registers are candidates, the youngest one decides the select: execute/mem1 first, then mem1/mem2, then mem2/write-back.
- R3: Loaded data is bypassed only from the mem2/write-back register. If the youngest candidate is a load in execute/mem1 or mem1/mem2, the select is 0.
- R4: Register index 0 never yields a nonzero select and never causes a stall.
- R5: A stall is raised when a decode source whose use flag is 1 matches the destination of a load with write-enable set in the decode/execute register or in the execute/mem1 register. A stall gives pc_en=0, ifid_en=0, idex_clr=1, ifid_clr=0.
- R6: No stall arises from an unused decode source, from a non-load producer, or from a load already in mem1/mem2 or later.
- R7: A redirect gives pc_en=1, ifid_en=1, ifid_clr=1, idex_clr=1, whether or not a stall condition also holds.
- R8: With no hazard and no redirect, the outputs are pc_en=1, ifid_en=1, ifid_clr=0, idex_clr=0.
- R9: A load followed directly by a dependent instruction costs two stall cycles. With one independent instruction between them it costs one, and with two or more it costs none. In each of these cases the dependent operand takes select 3 in execute when bypassing is still needed.
- R10: A store (write-enable 0) followed by a load is never a hazard: it causes neither a stall nor a bypass, whatever its destination field holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| idex_rs1 | input | 5 | First source index of the instruction in execute |
| idex_rs2 | input | 5 | Second source index of the instruction in execute |
| ifid_rs1 | input | 5 | First source index of the instruction in decode |
| ifid_rs2 | input | 5 | Second source index of the instruction in decode |
| ifid_use1 | input | 1 | Decode instruction reads its first source |
| ifid_use2 | input | 1 | Decode instruction reads its second source |
| idex_rd | input | 5 | Destination in the decode/execute register |
| idex_wen | input | 1 | Register write-enable in the decode/execute register |
| idex_load | input | 1 | Load flag in the decode/execute register |
| exm1_rd | input | 5 | Destination in the execute/mem1 register |
| exm1_wen | input | 1 | Write-enable in the execute/mem1 register |
| exm1_load | input | 1 | Load flag in the execute/mem1 register |
| m1m2_rd | input | 5 | Destination in the mem1/mem2 register |
| m1m2_wen | input | 1 | Write-enable in the mem1/mem2 register |
| m1m2_load | input | 1 | Load flag in the mem1/mem2 register |
| m2wb_rd | input | 5 | Destination in the mem2/write-back register |
| m2wb_wen | input | 1 | Write-enable in the mem2/write-back register |
| m2wb_load | input | 1 | Load flag in the mem2/write-back register |
| ex_redirect | input | 1 | Taken branch or jump resolved in execute |
| fwd_a | output | 2 | Bypass select for the first ALU operand |
| fwd_b | output | 2 | Bypass select for the second ALU operand |
| pc_en | output | 1 | PC load enable |
| ifid_en | output | 1 | Fetch/decode register enable |
| ifid_clr | output | 1 | Fetch/decode register clear |
| idex_clr | output | 1 | Decode/execute register clear (bubble) |

## Verification
The hardest case is the stall count across cycles. A single look at the ports shows only whether this cycle stalls. The count of two versus one stall cycles appears only once the load and its consumer move through the pipeline under the unit's own enables and clears.

The bench therefore keeps a small instruction pipeline model. The unit's outputs drive the model, and the model feeds the unit's inputs back. The bench runs short programs with zero to three fillers between a load and its user, and it counts the held cycles and records the select seen when the user reaches execute. Near-exhaustive sweeps over a reduced index range cover the priority, x0 and flush-override corners.

// File: rtl/hz6_pkg.sv
package hz6_pkg;

    parameter int IDX_W = 5;

    typedef enum logic [1:0] {
        FWD_RF = 2'd0,
        FWD_M1 = 2'd1,
        FWD_M2 = 2'd2,
        FWD_WB = 2'd3
    } fwd_sel_e;

    typedef enum logic [1:0] {
        PIPE_RUN   = 2'd0,
        PIPE_STALL = 2'd1,
        PIPE_FLUSH = 2'd2
    } pipe_mode_e;

    typedef struct packed {
        logic [IDX_W-1:0] rd;
        logic             wen;
        logic             load;
    } producer_t;

endpackage

// File: rtl/hz6_fwd_sel.sv
module hz6_fwd_sel
    import hz6_pkg::*;
#(
    parameter int W = IDX_W
) (
    input  logic [W-1:0] src,
    input  producer_t    p_m1,
    input  producer_t    p_m2,
    input  producer_t    p_wb,
    output fwd_sel_e     sel
);

    logic src_live;
    logic hit_m1;
    logic hit_m2;
    logic hit_wb;

    always_comb begin
        src_live = (src != '0);
        hit_m1   = src_live && p_m1.wen && (p_m1.rd == src);
        hit_m2   = src_live && p_m2.wen && (p_m2.rd == src);
        hit_wb   = src_live && p_wb.wen && (p_wb.rd == src);
    end

    // Youngest candidate decides; a load that is not yet back yields the register file
    always_comb begin
        if (hit_m1) begin
            sel = p_m1.load ? FWD_RF : FWD_M1;
        end else if (hit_m2) begin
            sel = p_m2.load ? FWD_RF : FWD_M2;
        end else if (hit_wb) begin
            sel = FWD_WB;
        end else begin
            sel = FWD_RF;
        end
    end

endmodule

// File: rtl/hz6_load_hazard.sv
module hz6_load_hazard
    import hz6_pkg::*;
#(
    parameter int W       = IDX_W,
    parameter int NUM_SRC = 2
) (
    input  logic [NUM_SRC-1:0][W-1:0] src,
    input  logic [NUM_SRC-1:0]        use_src,
    input  producer_t                 p_ex,
    input  producer_t                 p_m1,
    output logic                      stall_req
);

    logic [NUM_SRC-1:0] src_wait;

    // Loads in execute or mem1 cannot reach a consumer's execute cycle in time
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        logic live;
        logic wait_ex;
        logic wait_m1;
        always_comb begin
            live       = use_src[i] && (src[i] != '0);
            wait_ex    = p_ex.wen && p_ex.load && (p_ex.rd == src[i]);
            wait_m1    = p_m1.wen && p_m1.load && (p_m1.rd == src[i]);
            src_wait[i] = live && (wait_ex || wait_m1);
        end
    end

    assign stall_req = |src_wait;

endmodule

// File: rtl/hz6_pipe_ctrl.sv
module hz6_pipe_ctrl
    import hz6_pkg::*;
(
    input  logic stall_req,
    input  logic redirect,
    output logic pc_en,
    output logic ifid_en,
    output logic ifid_clr,
    output logic idex_clr
);

    pipe_mode_e mode;

    always_comb begin
        if (redirect) begin
            mode = PIPE_FLUSH;
        end else if (stall_req) begin
            mode = PIPE_STALL;
        end else begin
            mode = PIPE_RUN;
        end
    end

    always_comb begin
        unique case (mode)
            PIPE_STALL: begin
                pc_en    = 1'b0;
                ifid_en  = 1'b0;
                ifid_clr = 1'b0;
                idex_clr = 1'b1;
            end
            PIPE_FLUSH: begin
                pc_en    = 1'b1;
                ifid_en  = 1'b1;
                ifid_clr = 1'b1;
                idex_clr = 1'b1;
            end
            default: begin
                pc_en    = 1'b1;
                ifid_en  = 1'b1;
                ifid_clr = 1'b0;
                idex_clr = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/hz6_hazard_unit.sv
module hz6_hazard_unit
    import hz6_pkg::*;
(
    input  logic [4:0] idex_rs1,
    input  logic [4:0] idex_rs2,
    input  logic [4:0] ifid_rs1,
    input  logic [4:0] ifid_rs2,
    input  logic       ifid_use1,
    input  logic       ifid_use2,
    input  logic [4:0] idex_rd,
    input  logic       idex_wen,
    input  logic       idex_load,
    input  logic [4:0] exm1_rd,
    input  logic       exm1_wen,
    input  logic       exm1_load,
    input  logic [4:0] m1m2_rd,
    input  logic       m1m2_wen,
    input  logic       m1m2_load,
    input  logic [4:0] m2wb_rd,
    input  logic       m2wb_wen,
    input  logic       m2wb_load,
    input  logic       ex_redirect,
    output logic [1:0] fwd_a,
    output logic [1:0] fwd_b,
    output logic       pc_en,
    output logic       ifid_en,
    output logic       ifid_clr,
    output logic       idex_clr
);

    localparam int NUM_SRC = 2;

    producer_t p_ex;
    producer_t p_m1;
    producer_t p_m2;
    producer_t p_wb;

    assign p_ex = '{rd: idex_rd, wen: idex_wen, load: idex_load};
    assign p_m1 = '{rd: exm1_rd, wen: exm1_wen, load: exm1_load};
    assign p_m2 = '{rd: m1m2_rd, wen: m1m2_wen, load: m1m2_load};
    assign p_wb = '{rd: m2wb_rd, wen: m2wb_wen, load: m2wb_load};

    logic [NUM_SRC-1:0][IDX_W-1:0] ex_src;
    logic [NUM_SRC-1:0][IDX_W-1:0] id_src;
    logic [NUM_SRC-1:0]            id_use;
    fwd_sel_e                      sel [NUM_SRC];

    assign ex_src = {idex_rs2, idex_rs1};
    assign id_src = {ifid_rs2, ifid_rs1};
    assign id_use = {ifid_use2, ifid_use1};

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_fwd
        hz6_fwd_sel #(.W(IDX_W)) u_sel (
            .src  (ex_src[i]),
            .p_m1 (p_m1),
            .p_m2 (p_m2),
            .p_wb (p_wb),
            .sel  (sel[i])
        );
    end

    assign fwd_a = sel[0];
    assign fwd_b = sel[1];

    logic stall_req;

    hz6_load_hazard #(.W(IDX_W), .NUM_SRC(NUM_SRC)) u_lh (
        .src       (id_src),
        .use_src   (id_use),
        .p_ex      (p_ex),
        .p_m1      (p_m1),
        .stall_req (stall_req)
    );

    hz6_pipe_ctrl u_ctrl (
        .stall_req (stall_req),
        .redirect  (ex_redirect),
        .pc_en     (pc_en),
        .ifid_en   (ifid_en),
        .ifid_clr  (ifid_clr),
        .idex_clr  (idex_clr)
    );

    always_comb begin
        // R3
        fwd_m1_not_load_chk: assert (!(fwd_a == FWD_M1 && exm1_load))
            else $error("bypass from execute/mem1 of a load");
        // R2
        fwd_wb_youngest_chk: assert (!(fwd_a == FWD_WB && exm1_wen && exm1_rd == idex_rs1))
            else $error("older bypass chosen over a younger match");
        // R4
        x0_no_fwd_chk: assert (!(idex_rs1 == 5'd0 && fwd_a != FWD_RF))
            else $error("bypass selected for x0");
        // R7
        flush_wins_chk: assert (!ex_redirect || (pc_en && ifid_clr && idex_clr))
            else $error("redirect did not flush");
        // R5
        stall_bubble_chk: assert (pc_en || (idex_clr && !ifid_en && !ifid_clr))
            else $error("held PC without a bubble");
    end

endmodule

// File: tb/tb_hz6_hazard_unit.sv
module tb_hz6_hazard_unit;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic [4:0] idex_rs1, idex_rs2, ifid_rs1, ifid_rs2;
    logic       ifid_use1, ifid_use2;
    logic [4:0] idex_rd, exm1_rd, m1m2_rd, m2wb_rd;
    logic       idex_wen, idex_load, exm1_wen, exm1_load;
    logic       m1m2_wen, m1m2_load, m2wb_wen, m2wb_load;
    logic       ex_redirect;
    logic [1:0] fwd_a, fwd_b;
    logic       pc_en, ifid_en, ifid_clr, idex_clr;

    hz6_hazard_unit dut (.*);

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    typedef struct packed {
        logic [4:0] rd;
        logic [4:0] rs1;
        logic [4:0] rs2;
        logic       wen;
        logic       load;
        logic       u1;
        logic       u2;
        logic       tag;
    } ins_t;

    localparam ins_t NOP = '0;

    ins_t s_ifid, s_idex, s_exm1, s_m1m2, s_m2wb;
    ins_t prog [8];
    int   pc;

    // Expected select from R1..R4
    function automatic logic [1:0] exp_fwd(input logic [4:0] rs,
            input logic [4:0] r1, input logic w1, input logic l1,
            input logic [4:0] r2, input logic w2, input logic l2,
            input logic [4:0] r3, input logic w3);
        if (rs == 0) return 2'd0;
        if (w1 && r1 == rs) return l1 ? 2'd0 : 2'd1;
        if (w2 && r2 == rs) return l2 ? 2'd0 : 2'd2;
        if (w3 && r3 == rs) return 2'd3;
        return 2'd0;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive_model();
        idex_rs1 = s_idex.rs1;  idex_rs2 = s_idex.rs2;
        ifid_rs1 = s_ifid.rs1;  ifid_rs2 = s_ifid.rs2;
        ifid_use1 = s_ifid.u1;  ifid_use2 = s_ifid.u2;
        idex_rd = s_idex.rd;    idex_wen = s_idex.wen;  idex_load = s_idex.load;
        exm1_rd = s_exm1.rd;    exm1_wen = s_exm1.wen;  exm1_load = s_exm1.load;
        m1m2_rd = s_m1m2.rd;    m1m2_wen = s_m1m2.wen;  m1m2_load = s_m1m2.load;
        m2wb_rd = s_m2wb.rd;    m2wb_wen = s_m2wb.wen;  m2wb_load = s_m2wb.load;
        ex_redirect = 1'b0;
    endtask

    task automatic model_reset();
        s_ifid = NOP; s_idex = NOP; s_exm1 = NOP; s_m1m2 = NOP; s_m2wb = NOP;
        pc = 0;
        drive_model();
    endtask

    // Runs prog through the model; returns held cycles and select seen by the tagged op
    task automatic run_prog(output int stalls, output logic [1:0] tag_sel);
        model_reset();
        stalls  = 0;
        tag_sel = 2'bxx;
        for (int c = 0; c < 14; c++) begin
            @(negedge clk);
            if (!pc_en) stalls++;
            if (s_idex.tag) tag_sel = fwd_a;
            s_m2wb = s_m1m2;
            s_m1m2 = s_exm1;
            s_exm1 = s_idex;
            s_idex = idex_clr ? NOP : s_ifid;
            if (ifid_clr) s_ifid = NOP;
            else if (ifid_en) s_ifid = (pc < 8) ? prog[pc] : NOP;
            if (pc_en) pc++;
            drive_model();
        end
    endtask

    function automatic ins_t mk(input logic [4:0] rd, input logic [4:0] rs1,
            input logic wen, input logic load, input logic u1, input logic tag);
        ins_t t = NOP;
        t.rd = rd; t.rs1 = rs1; t.wen = wen; t.load = load; t.u1 = u1; t.tag = tag;
        return t;
    endfunction

    initial begin
        int st;
        logic [1:0] ts;

        // R8: idle pipeline, no hazard
        model_reset();
        #3;
        check(pc_en && ifid_en && !ifid_clr && !idex_clr && fwd_a == 0 && fwd_b == 0,
              "R8 idle", {pc_en, ifid_en, ifid_clr, idex_clr}, 4'b1100);

        // R1 R2 R3 R4: sweep over indices 0..3 in three producer registers
        ex_redirect = 0; ifid_use1 = 0; ifid_use2 = 0; idex_wen = 0; idex_load = 0;
        ifid_rs1 = 0; ifid_rs2 = 0; idex_rd = 0;
        for (int rs = 0; rs < 4; rs++) begin
            for (int v = 0; v < 4096; v++) begin
                logic [1:0] ea, eb;
                idex_rs1 = 5'(rs);
                idex_rs2 = 5'(3 - rs);
                exm1_rd = 5'(v[1:0]);   exm1_wen = v[2];  exm1_load = v[3];
                m1m2_rd = 5'(v[5:4]);   m1m2_wen = v[6];  m1m2_load = v[7];
                m2wb_rd = 5'(v[9:8]);   m2wb_wen = v[10]; m2wb_load = v[11];
                #2;
                ea = exp_fwd(idex_rs1, exm1_rd, exm1_wen, exm1_load,
                             m1m2_rd, m1m2_wen, m1m2_load, m2wb_rd, m2wb_wen);
                eb = exp_fwd(idex_rs2, exm1_rd, exm1_wen, exm1_load,
                             m1m2_rd, m1m2_wen, m1m2_load, m2wb_rd, m2wb_wen);
                check(fwd_a == ea, "R1/R2/R3/R4 fwd_a", fwd_a, ea);
                check(fwd_b == eb, "R1/R2/R3/R4 fwd_b", fwd_b, eb);
            end
        end

        // R5 R6 R7 R8 R10: sweep of decode operands against loads/stores in execute and mem1
        idex_rs1 = 0; idex_rs2 = 0;
        m1m2_rd = 5'd1; m1m2_wen = 1; m1m2_load = 1;
        m2wb_rd = 0; m2wb_wen = 0; m2wb_load = 0;
        for (int v = 0; v < 32768; v++) begin
            bit s, hz;
            logic [3:0] got, exp;
            ifid_rs1 = 5'(v[1:0]);  ifid_rs2 = 5'(v[3:2]);
            ifid_use1 = v[4];       ifid_use2 = v[5];
            idex_rd = 5'(v[7:6]);   idex_wen = v[8];  idex_load = v[9];
            exm1_rd = 5'(v[11:10]); exm1_wen = v[12]; exm1_load = v[13];
            ex_redirect = v[14];
            #2;
            s = 0;
            if (ifid_use1 && ifid_rs1 != 0 &&
                ((idex_wen && idex_load && idex_rd == ifid_rs1) ||
                 (exm1_wen && exm1_load && exm1_rd == ifid_rs1))) s = 1;
            if (ifid_use2 && ifid_rs2 != 0 &&
                ((idex_wen && idex_load && idex_rd == ifid_rs2) ||
                 (exm1_wen && exm1_load && exm1_rd == ifid_rs2))) s = 1;
            hz = s;
            if (ex_redirect) exp = 4'b1111;
            else if (hz)     exp = 4'b0001;
            else             exp = 4'b1100;
            got = {pc_en, ifid_en, ifid_clr, idex_clr};
            check(got == exp, "R5/R6/R7 control", got, exp);
        end

        // R9: load then user with 0..3 fillers between
        for (int k = 0; k < 4; k++) begin
            int n;
            for (int i = 0; i < 8; i++) prog[i] = NOP;
            n = 0;
            prog[n++] = mk(5'd5, 5'd2, 1, 1, 1, 0);
            for (int f = 0; f < k; f++) prog[n++] = mk(5'd7, 5'd1, 1, 0, 1, 0);
            prog[n] = mk(5'd6, 5'd5, 1, 0, 1, 1);
            run_prog(st, ts);
            check(st == ((k < 2) ? 2 - k : 0), "R9 stall count", st, (k < 2) ? 2 - k : 0);
            check(ts == ((k < 3) ? 2'd3 : 2'd0), "R9 user select", ts, (k < 3) ? 3 : 0);
        end

        // R2: ALU producer directly followed by user takes execute/mem1 with no stall
        for (int i = 0; i < 8; i++) prog[i] = NOP;
        prog[0] = mk(5'd5, 5'd2, 1, 0, 1, 0);
        prog[1] = mk(5'd6, 5'd5, 1, 0, 1, 1);
        run_prog(st, ts);
        check(st == 0, "R2 alu chain stalls", st, 0);
        check(ts == 2'd1, "R2 alu chain select", ts, 1);

        // R10: store (destination field 9, wen 0) then load whose base is x9
        for (int i = 0; i < 8; i++) prog[i] = NOP;
        prog[0] = mk(5'd9, 5'd3, 0, 0, 1, 0);
        prog[1] = mk(5'd8, 5'd9, 1, 1, 1, 1);
        run_prog(st, ts);
        check(st == 0, "R10 store-load stalls", st, 0);
        check(ts == 2'd0, "R10 store-load select", ts, 0);

        done = 1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule